// File: doc/BRIEF.md
# Alternating Dual-Register Capture Unit

This block sits next to a free-running counter and takes snapshots of its value when capture events occur. A capture event comes either from a rising edge on an asynchronous external line or from a one-cycle software strobe. Successive captures land alternately in two holding registers: the first in register 0, the next in register 1, then back to register 0, and so on.

The unit captures only while both the two-register mode bit and the register-0-capture bit are set. Clearing the two-register mode bit parks the alternation pointer on register 0. Each register has its own sticky capture flag. The interrupt output is either the AND or the OR of the two flags, chosen by a select bit. One acknowledge pulse clears both flags.

The alternation pointer is a three-state machine:

- ST_OFF: the mode bit is clear and the pointer rests on register 0.
- ST_PTR0: the mode is on and the next capture goes to register 0.
- ST_PTR1: the mode is on and the next capture goes to register 1.

Its transitions are:

- T_DISABLE: from any state to ST_OFF whenever bival_en is low.
- T_ARM: from ST_OFF to ST_PTR0 when bival_en is high and no capture fires.
- T_TO1: from ST_OFF or ST_PTR0 to ST_PTR1 on a capture into register 0.
- T_TO0: from ST_PTR1 to ST_PTR0 on a capture into register 1.
- T_HOLD: the state is unchanged in every other case.

Top module: `altcap_unit`

## Requirements
- R1: A capture happens only in a cycle where both bival_en and reg0_cap_en are 1. In any other cycle, events change neither capture register and neither flag.
- R2: ext_in passes through two synchronising flip-flops, and a capture fires on its rising edge. Suppose ext_in goes from 0 to 1 before clock edge k, with edge k being the first edge that samples it high. Then the capture happens at edge k+2 and stores the cnt_val present at edge k+2.
- R3: Captures alternate between the two registers, starting with cap0_val. Each capture stores the cnt_val sampled at the capturing clock edge, and the other register keeps its value.
- R4: A clock edge with bival_en = 0 sends the pointer to register 0. The first capture after the mode is re-enabled therefore goes to cap0_val, even if the pointer was previously on register 1.
- R5: A capture sets the sticky flag of the register it loaded. A cycle with irq_ack = 1 clears both flags. A capture in the same cycle as the acknowledge leaves its own flag set.
- R6: With irq_and_sel = 1, irq is 1 exactly when both flags are set. With irq_and_sel = 0, irq is 1 when either flag is set. irq follows the flags and irq_and_sel without any further register.
- R7: A sw_cap pulse and a synchronised ext_in rising edge in the same cycle count as one capture, and the pointer advances by one.
- R8: Reset (rst_n = 0, asynchronous) clears both registers and both flags, and puts the pointer on register 0.
- R9: Every cycle in which sw_cap is 1 with the mode active is a separate capture. Holding sw_cap for two cycles fills both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| ext_in | input | 1 | Asynchronous external capture line |
| sw_cap | input | 1 | Software capture strobe, one capture per high cycle |
| bival_en | input | 1 | Two-register mode bit; low parks the pointer on register 0 |
| reg0_cap_en | input | 1 | Register-0-as-capture bit |
| irq_and_sel | input | 1 | 1 = interrupt on AND of flags, 0 = OR |
| irq_ack | input | 1 | Clears both capture flags |
| cap0_val | output | CNT_W | Capture register 0 |
| cap1_val | output | CNT_W | Capture register 1 |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a software strobe and a synchronised external edge. The bench raises ext_in, waits two edges, and then drives sw_cap so that it lands in the capture cycle. It then judges from the ports that only one register took a value and that the next strobe goes to the other register. The second pair is an acknowledge and a capture. The bench drives both together and checks that the freshly loaded flag keeps irq high in OR mode. A behavioural reference model, compared on every clock, covers the rest.

// File: rtl/altcap_pkg.sv
package altcap_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PTR0 = 2'd1,
        ST_PTR1 = 2'd2
    } cap_state_e;

    typedef enum logic {
        SEL_R0 = 1'b0,
        SEL_R1 = 1'b1
    } cap_sel_e;

endpackage

// File: rtl/altcap_sync.sv
module altcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES synchroniser flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= 1'b0;
        end else begin
            pipe_q[0] <= din;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[i] <= 1'b0;
            end else begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/altcap_seq.sv
module altcap_seq
    import altcap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bival_en,
    input  logic     mode_act,
    input  logic     event_in,
    output logic     cap_fire,
    output cap_sel_e cap_sel
);
    cap_state_e state_q;
    cap_state_e state_d;

    assign cap_fire = mode_act & event_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_DISABLE, T_TO1, T_TO0, T_ARM, T_HOLD
    always_comb begin
        state_d = state_q;
        if (!bival_en) begin
            state_d = ST_OFF;
        end else if (cap_fire) begin
            state_d = (cap_sel == SEL_R0) ? ST_PTR1 : ST_PTR0;
        end else if (state_q == ST_OFF) begin
            state_d = ST_PTR0;
        end
    end

    // outputs
    always_comb begin
        cap_sel = SEL_R0;
        unique case (state_q)
            ST_OFF:  cap_sel = SEL_R0;
            ST_PTR0: cap_sel = SEL_R0;
            ST_PTR1: cap_sel = SEL_R1;
            default: cap_sel = SEL_R0;
        endcase
    end

endmodule

// File: rtl/altcap_bank.sv
module altcap_bank #(
    parameter int W    = 16,
    parameter int NREG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        cnt_val,
    input  logic                cap_fire,
    input  logic                sel,
    input  logic                irq_ack,
    input  logic                irq_and_sel,
    output logic [NREG*W-1:0]   regs_flat,
    output logic [NREG-1:0]     flags,
    output logic                irq
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic          hit;
        logic [W-1:0]  val_q;
        logic          flag_q;

        assign hit = cap_fire && (sel == i[0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q  <= '0;
                flag_q <= 1'b0;
            end else begin
                if (hit) begin
                    val_q <= cnt_val;
                end
                if (hit) begin
                    flag_q <= 1'b1;
                end else if (irq_ack) begin
                    flag_q <= 1'b0;
                end
            end
        end

        assign regs_flat[i*W +: W] = val_q;
        assign flags[i]            = flag_q;
    end

    assign irq = irq_and_sel ? (&flags) : (|flags);

endmodule

// File: rtl/altcap_unit.sv
module altcap_unit
    import altcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             ext_in,
    input  logic             sw_cap,
    input  logic             bival_en,
    input  logic             reg0_cap_en,
    input  logic             irq_and_sel,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] cap0_val,
    output logic [CNT_W-1:0] cap1_val,
    output logic             irq
);
    localparam int NREG = 2;

    logic               ext_rise;
    logic               mode_act;
    logic               cap_fire;
    cap_sel_e           cap_sel;
    logic [NREG*CNT_W-1:0] regs_flat;
    logic [NREG-1:0]    flags_w;

    assign mode_act = bival_en & reg0_cap_en;

    altcap_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .rise (ext_rise)
    );

    altcap_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .bival_en(bival_en),
        .mode_act(mode_act),
        .event_in(sw_cap | ext_rise),
        .cap_fire(cap_fire),
        .cap_sel (cap_sel)
    );

    altcap_bank #(.W(CNT_W), .NREG(NREG)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_val    (cnt_val),
        .cap_fire   (cap_fire),
        .sel        (cap_sel == SEL_R1),
        .irq_ack    (irq_ack),
        .irq_and_sel(irq_and_sel),
        .regs_flat  (regs_flat),
        .flags      (flags_w),
        .irq        (irq)
    );

    assign cap0_val = regs_flat[0 +: CNT_W];
    assign cap1_val = regs_flat[CNT_W +: CNT_W];

endmodule

// File: rtl/altcap_unit_chk.sv
module altcap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bival_en,
    input logic             reg0_cap_en,
    input logic             irq_and_sel,
    input logic             irq_ack,
    input logic [CNT_W-1:0] cap0_val,
    input logic [CNT_W-1:0] cap1_val,
    input logic             irq,
    input logic             ptr_r1,
    input logic             flag0,
    input logic             flag1
);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bival_en && reg0_cap_en) |=> ($stable(cap0_val) && $stable(cap1_val)));

    assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(cap0_val) && !$stable(cap1_val)));

    assert_ptr_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bival_en |=> !ptr_r1);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag0 && !irq_ack) |=> flag0);

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(bival_en && reg0_cap_en)) |=> !irq);

    assert_and_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_and_sel && !flag1) |-> !irq);

endmodule

bind altcap_unit altcap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bival_en   (bival_en),
    .reg0_cap_en(reg0_cap_en),
    .irq_and_sel(irq_and_sel),
    .irq_ack    (irq_ack),
    .cap0_val   (cap0_val),
    .cap1_val   (cap1_val),
    .irq        (irq),
    .ptr_r1     (cap_sel == altcap_pkg::SEL_R1),
    .flag0      (flags_w[0]),
    .flag1      (flags_w[1])
);

// File: tb/altcap_unit_tb.sv
module altcap_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         ext_in = 1'b0;
    logic         sw_cap = 1'b0;
    logic         bival_en = 1'b0;
    logic         reg0_cap_en = 1'b0;
    logic         irq_and_sel = 1'b0;
    logic         irq_ack = 1'b0;
    logic [W-1:0] cap0_val;
    logic [W-1:0] cap1_val;
    logic         irq;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_r0 = 0, m_r1 = 0, m_ptr = 0;
    bit m_f0 = 0, m_f1 = 0;
    bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

    altcap_unit #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .ext_in(ext_in),
        .sw_cap(sw_cap), .bival_en(bival_en), .reg0_cap_en(reg0_cap_en),
        .irq_and_sel(irq_and_sel), .irq_ack(irq_ack),
        .cap0_val(cap0_val), .cap1_val(cap1_val), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cnt_val <= cnt_val + 16'd7;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_r0 = 0; m_r1 = 0; m_ptr = 0; m_f0 = 0; m_f1 = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit ev;
            bit hit0;
            bit hit1;
            ev   = sw_cap || (m_s2 && !m_s3);
            hit0 = 0;
            hit1 = 0;
            if (bival_en && reg0_cap_en && ev) begin
                if (m_ptr == 0) begin
                    m_r0 = int'(cnt_val);
                    hit0 = 1;
                end else begin
                    m_r1 = int'(cnt_val);
                    hit1 = 1;
                end
                m_ptr = 1 - m_ptr;
            end
            if (!bival_en) m_ptr = 0;
            if (irq_ack) begin m_f0 = 0; m_f1 = 0; end
            if (hit0) m_f0 = 1;
            if (hit1) m_f1 = 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the reference
    always @(negedge clk) begin
        if (rst_n) begin
            bit m_irq;
            m_irq = irq_and_sel ? (m_f0 && m_f1) : (m_f0 || m_f1);
            chk("R3 model cap0", int'(cap0_val), m_r0);
            chk("R3 model cap1", int'(cap1_val), m_r1);
            chk("R6 model irq", int'(irq), int'(m_irq));
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one-cycle software strobe; returns the value the capture should store
    task automatic strobe(output int v);
        v = int'(cnt_val);
        sw_cap = 1'b1;
        step();
        sw_cap = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v0, v1, v2, old0, old1;
        step(3);
        // R8: reset state
        chk("R8 cap0 reset", int'(cap0_val), 0);
        chk("R8 cap1 reset", int'(cap1_val), 0);
        chk("R8 irq reset", int'(irq), 0);
        rst_n = 1'b1;
        step(2);

        // R1: events ignored while the mode is incomplete
        bival_en = 1'b1;
        reg0_cap_en = 1'b0;
        strobe(v0);
        step();
        chk("R1 cap0 unchanged", int'(cap0_val), 0);
        chk("R1 irq stays low", int'(irq), 0);

        // R3 / R6 OR mode
        reg0_cap_en = 1'b1;
        strobe(v0);
        chk("R3 first capture to cap0", int'(cap0_val), v0);
        chk("R6 OR irq on one flag", int'(irq), 1);
        irq_and_sel = 1'b1;
        step();
        chk("R6 AND irq with one flag", int'(irq), 0);
        strobe(v1);
        chk("R3 second capture to cap1", int'(cap1_val), v1);
        chk("R3 cap0 kept", int'(cap0_val), v0);
        chk("R6 AND irq with both", int'(irq), 1);

        // R5 acknowledge
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R5 ack clears irq", int'(irq), 0);
        irq_and_sel = 1'b0;
        step();
        chk("R5 flags cleared OR", int'(irq), 0);

        // R5: capture and acknowledge in the same cycle
        irq_ack = 1'b1;
        strobe(v2);
        irq_ack = 1'b0;
        chk("R5 capture beats ack", int'(irq), 1);
        chk("R3 third capture to cap0", int'(cap0_val), v2);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;

        // R4: pointer is on register 1 now; park and re-enable
        old1 = int'(cap1_val);
        bival_en = 1'b0;
        step(2);
        bival_en = 1'b1;
        strobe(v0);
        chk("R4 restart into cap0", int'(cap0_val), v0);
        chk("R4 cap1 untouched", int'(cap1_val), old1);

        // R2: external edge, capture at third edge
        strobe(v1);
        old0 = int'(cap0_val);
        ext_in = 1'b1;
        step(2);
        chk("R2 no capture before sync", int'(cap0_val), old0);
        v0 = int'(cnt_val);
        step();
        chk("R2 capture after sync", int'(cap0_val), v0);
        ext_in = 1'b0;
        step(4);

        // R7: external edge and strobe together
        old1 = int'(cap1_val);
        ext_in = 1'b1;
        step(2);
        strobe(v1);
        chk("R7 single capture into cap1", int'(cap1_val), v1);
        old0 = int'(cap0_val);
        step();
        chk("R7 no extra capture", int'(cap0_val), old0);
        strobe(v2);
        chk("R7 next goes to cap0", int'(cap0_val), v2);
        ext_in = 1'b0;

        // R9: strobe held for two cycles
        v0 = int'(cnt_val);
        sw_cap = 1'b1;
        step();
        v1 = int'(cnt_val);
        step();
        sw_cap = 1'b0;
        chk("R9 held strobe cap1", int'(cap1_val), v0);
        chk("R9 held strobe cap0", int'(cap0_val), v1);
        step(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule